// File: doc/BRIEF.md
# Q15 Recursive Sample Filter

This block is a direct-form recursive (IIR) filter for 16-bit Q15 sample streams. Each accepted input sample is first shifted right arithmetically by a power-of-two prescale. It is then combined with the stored past inputs and past outputs, each weighted by a fixed Q15 coefficient. The products are summed in a 40-bit accumulator. The sum is brought back to Q15 by an arithmetic right shift of 15 bits, and an overflow policy set at elaboration is then applied: clip or wrap.

The requantized result is registered as the output sample. The same 16-bit value is pushed into the feedback history, so later outputs use the truncated output and not the full accumulator. The numbers of feed-forward and feedback taps are parameters from 1 to 4, and the coefficients are packed parameter vectors. After reset all history is zero, which makes every earlier input and output count as 0.

Both stream edges use a valid/ready handshake. A sample moves when `in_valid` and `in_ready` are both high at a rising edge. A result moves when `out_valid` and `out_ready` are both high. At most one result is held. Input is accepted whenever the output register is empty or is being drained in the same cycle. A consumer that holds `out_ready` low therefore stalls the producer after one result.

Top module: `q15_recursive_filter`

## Requirements
- R1: After a cycle with the synchronous active-high `rst` high, `out_valid` is 0, `in_ready` is 1 and both history lines are zero. The first output after reset is therefore floor(b0*xs/2^15), where xs is the prescaled input.
- R2: For each accepted sample the output is floor((sum of b_i*xs(n-i) + sum of a_j*y(n-1-j)) / 2^15), summed exactly in 40 bits. The default taps are b0=0x4000, b1=0x199A, a0=0x4000, a1=0x199A. Coefficient i sits in bits [16i+15:16i] of its packed parameter.
- R3: The value that enters the feedback history is the 16-bit requantized output, the same value that appears on `out_data`.
- R4: Both history lines advance by exactly one position per accepted sample, with the newest value at index 0. They hold their contents in every other cycle, including stalls and idle cycles.
- R5: With SATURATE=1, a shifted result above 32767 gives 0x7FFF and one below -32768 gives 0x8000.
- R6: With SATURATE=0, the output is the low 16 bits of the shifted result (two's-complement wrap), and that wrapped value is what is fed back.
- R7: The input sample is arithmetically shifted right by IN_SHIFT bits before it reaches the multipliers and the input history.
- R8: `out_valid` is 1 in the cycle after an accepted sample. While `out_valid` is 1 and `out_ready` is 0, both `out_valid` and `out_data` keep their values.
- R9: `in_ready` equals (not `out_valid`) or `out_ready`. A sample may be accepted in the same cycle the held result is taken. If a result is taken and no sample is accepted, `out_valid` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_data | input | 16 | Signed Q15 input sample |
| out_valid | output | 1 | Output sample held |
| out_ready | input | 1 | Consumer takes the output this cycle |
| out_data | output | 16 | Signed Q15 output sample |

## Verification
Taking a held result and accepting the next sample can happen at the same clock edge. In that cycle the output register is both drained and reloaded, and both history lines shift. The bench provokes this by driving `out_ready` and `in_valid` high together, many times in random runs and in long back-to-back bursts. It judges each such cycle at the ports: the old value must be taken unchanged, and the next result must be the one a reference model gives after exactly one history step. A second instance, with wrap and a prescale of one bit, receives the same traffic, so overflow wrap and clipping both land in these merged cycles.

// File: rtl/iirf_pkg.sv
package iirf_pkg;
  localparam int SAMPLE_W  = 16;
  localparam int FRAC_BITS = 15;
  localparam int ACC_W     = 40;
  localparam int PROD_W    = 2 * SAMPLE_W;
  localparam int EXT_W     = ACC_W - PROD_W;
  localparam int MAX_TAPS  = 4;

  typedef logic signed [SAMPLE_W-1:0] sample_t;
  typedef logic signed [PROD_W-1:0]   prod_t;
  typedef logic signed [ACC_W-1:0]    acc_t;
endpackage

// File: rtl/iirf_history.sv
module iirf_history
  import iirf_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      shift_en,
  input  sample_t                   din,
  output logic [DEPTH*SAMPLE_W-1:0] taps
);
  sample_t stage [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
    end else if (shift_en) begin
      stage[0] <= din;
      for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_tap
    assign taps[g*SAMPLE_W +: SAMPLE_W] = stage[g];
  end
endmodule

// File: rtl/iirf_mac.sv
module iirf_mac
  import iirf_pkg::*;
#(
  parameter int NFF = 2,
  parameter int NFB = 2,
  parameter int XD  = 1,
  parameter logic [MAX_TAPS*SAMPLE_W-1:0] FF_COEFS = '0,
  parameter logic [MAX_TAPS*SAMPLE_W-1:0] FB_COEFS = '0
) (
  input  sample_t                   x_now,
  input  logic [XD*SAMPLE_W-1:0]    x_past,
  input  logic [NFB*SAMPLE_W-1:0]   y_past,
  output acc_t                      acc
);
  prod_t ff_prod [NFF];
  prod_t fb_prod [NFB];

  for (genvar i = 0; i < NFF; i++) begin : g_ff
    sample_t opnd;
    if (i == 0) begin : g_now
      assign opnd = x_now;
    end else begin : g_old
      assign opnd = x_past[(i-1)*SAMPLE_W +: SAMPLE_W];
    end
    assign ff_prod[i] = $signed(FF_COEFS[i*SAMPLE_W +: SAMPLE_W]) * opnd;
  end

  for (genvar j = 0; j < NFB; j++) begin : g_fb
    sample_t opnd;
    assign opnd       = y_past[j*SAMPLE_W +: SAMPLE_W];
    assign fb_prod[j] = $signed(FB_COEFS[j*SAMPLE_W +: SAMPLE_W]) * opnd;
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < NFF; i++)
      acc = acc + {{EXT_W{ff_prod[i][PROD_W-1]}}, ff_prod[i]};
    for (int j = 0; j < NFB; j++)
      acc = acc + {{EXT_W{fb_prod[j][PROD_W-1]}}, fb_prod[j]};
  end
endmodule

// File: rtl/iirf_requant.sv
module iirf_requant
  import iirf_pkg::*;
#(
  parameter bit SATURATE = 1'b1
) (
  input  acc_t    acc,
  output sample_t y
);
  localparam longint MAX_L = (longint'(1) <<< (SAMPLE_W - 1)) - 1;
  localparam longint MIN_L = -(longint'(1) <<< (SAMPLE_W - 1));
  localparam acc_t   MAX_A = acc_t'(MAX_L);
  localparam acc_t   MIN_A = acc_t'(MIN_L);

  acc_t wide;
  assign wide = acc >>> FRAC_BITS;

  if (SATURATE) begin : g_clip
    always_comb begin
      if (wide > MAX_A)      y = sample_t'(MAX_L);
      else if (wide < MIN_A) y = sample_t'(MIN_L);
      else                   y = wide[SAMPLE_W-1:0];
    end
  end else begin : g_wrap
    assign y = wide[SAMPLE_W-1:0];
  end
endmodule

// File: rtl/q15_recursive_filter.sv
module q15_recursive_filter
  import iirf_pkg::*;
#(
  parameter int NFF      = 2,
  parameter int NFB      = 2,
  parameter logic [MAX_TAPS*SAMPLE_W-1:0] FF_COEFS = {16'h0000, 16'h0000, 16'h199A, 16'h4000},
  parameter logic [MAX_TAPS*SAMPLE_W-1:0] FB_COEFS = {16'h0000, 16'h0000, 16'h199A, 16'h4000},
  parameter int IN_SHIFT = 0,
  parameter bit SATURATE = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic signed [SAMPLE_W-1:0] in_data,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic signed [SAMPLE_W-1:0] out_data
);
  localparam int XD = (NFF > 1) ? NFF - 1 : 1;

  logic                      accept;
  sample_t                   x_scaled;
  sample_t                   y_next;
  acc_t                      acc;
  logic [XD*SAMPLE_W-1:0]    x_hist;
  logic [NFB*SAMPLE_W-1:0]   y_hist;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign x_scaled = in_data >>> IN_SHIFT;

  iirf_history #(.DEPTH(XD)) u_xhist (
    .clk(clk), .rst(rst), .shift_en(accept), .din(x_scaled), .taps(x_hist)
  );

  iirf_history #(.DEPTH(NFB)) u_yhist (
    .clk(clk), .rst(rst), .shift_en(accept), .din(y_next), .taps(y_hist)
  );

  iirf_mac #(
    .NFF(NFF), .NFB(NFB), .XD(XD), .FF_COEFS(FF_COEFS), .FB_COEFS(FB_COEFS)
  ) u_mac (
    .x_now(x_scaled), .x_past(x_hist), .y_past(y_hist), .acc(acc)
  );

  iirf_requant #(.SATURATE(SATURATE)) u_rq (
    .acc(acc), .y(y_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_data  <= y_next;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && x_hist == '0 && y_hist == '0)); // R1
  AST_FEEDBACK_TAP: assert property (@(posedge clk) disable iff (rst)
    accept |=> (y_hist[SAMPLE_W-1:0] == out_data)); // R3
  AST_HIST_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !accept |=> ($stable(x_hist) && $stable(y_hist))); // R4
  AST_INPUT_TAP: assert property (@(posedge clk) disable iff (rst)
    accept |=> (x_hist[SAMPLE_W-1:0] == $past(x_scaled))); // R7
  AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid); // R8
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8
  AST_DRAIN_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (!accept && out_valid && out_ready) |=> !out_valid); // R9
endmodule

// File: tb/sim_q15_recursive_filter.sv
module sim_q15_recursive_filter;
  localparam int PERIOD = 10;
  localparam int B0 = 16384, B1 = 6554, A0 = 16384, A1 = 6554;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic signed [15:0] in_data = '0;
  logic ir [2];
  logic ov [2];
  logic signed [15:0] od [2];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int sh [2] = '{0, 1};
  bit sat [2] = '{1'b1, 1'b0};
  int xh [2];
  int yh [2][2];
  int exp_val [2];
  int exp_kind [2];
  bit exp_first [2];
  bit first_pending [2];
  bit want_valid [2];
  bit want_idle [2];
  bit want_hold [2];
  int hold_val [2];

  always #(PERIOD/2) clk = ~clk;

  q15_recursive_filter u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(ir[0]), .in_data(in_data),
    .out_valid(ov[0]), .out_ready(out_ready), .out_data(od[0])
  );

  q15_recursive_filter #(.IN_SHIFT(1), .SATURATE(1'b0)) u1 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(ir[1]), .in_data(in_data),
    .out_valid(ov[1]), .out_ready(out_ready), .out_data(od[1])
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, expv, $time);
    end
  endtask

  function automatic void model_clear(input int d);
    xh[d] = 0; yh[d][0] = 0; yh[d][1] = 0;
    first_pending[d] = 1'b1;
  endfunction

  function automatic void model_step(input int d, input int x);
    int xs;
    longint acc;
    longint q;
    int y;
    xs  = x >>> sh[d];
    acc = longint'(B0) * xs + longint'(B1) * xh[d] +
          longint'(A0) * yh[d][0] + longint'(A1) * yh[d][1];
    q   = acc >>> 15;
    exp_kind[d] = 0;
    if (sat[d]) begin
      if (q > 32767)       begin y = 32767;  exp_kind[d] = 1; end
      else if (q < -32768) begin y = -32768; exp_kind[d] = 1; end
      else y = int'(q);
    end else begin
      y = int'(shortint'(q));
      if (longint'(y) != q) exp_kind[d] = 2;
    end
    xh[d] = xs;
    yh[d][1] = yh[d][0];
    yh[d][0] = y;
    exp_val[d] = y;
    exp_first[d] = first_pending[d];
    first_pending[d] = 1'b0;
  endfunction

  // one cycle: judge results of the last edge, drive, then evaluate handshakes for the next edge
  task automatic cycle(input bit v, input int data, input bit rdy);
    @(negedge clk);
    for (int d = 0; d < 2; d++) begin
      if (want_valid[d]) check(ov[d] == 1'b1, "R8 valid after accept", int'(ov[d]), 1);
      if (want_idle[d])  check(ov[d] == 1'b0, "R9 valid drops after drain", int'(ov[d]), 0);
      if (want_hold[d])  check(ov[d] && int'(od[d]) == hold_val[d], "R8 stall hold", int'(od[d]), hold_val[d]);
      want_valid[d] = 0; want_idle[d] = 0; want_hold[d] = 0;
    end
    in_valid  = v;
    in_data   = 16'(data);
    out_ready = rdy;
    #1;
    for (int d = 0; d < 2; d++) begin
      bit fin, fout;
      check(ir[d] == (!ov[d] || rdy), "R9 ready rule", int'(ir[d]), int'(!ov[d] || rdy));
      fout = ov[d] && rdy;
      fin  = v && ir[d];
      if (fout) begin
        string tag;
        if (exp_first[d])       tag = "R1 first output";
        else if (exp_kind[d] == 1) tag = "R5 clip";
        else if (exp_kind[d] == 2) tag = "R6 wrap";
        else                    tag = (d == 1) ? "R2/R3/R4/R7 output" : "R2/R3/R4 output";
        check(int'(od[d]) == exp_val[d], tag, int'(od[d]), exp_val[d]);
      end
      if (ov[d] && !rdy) begin
        want_hold[d] = 1; hold_val[d] = int'(od[d]);
      end
      if (fin) begin
        model_step(d, data);
        want_valid[d] = 1;
      end else if (fout) begin
        want_idle[d] = 1;
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 0; out_ready = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int d = 0; d < 2; d++) begin
      model_clear(d);
      want_valid[d] = 0; want_idle[d] = 0; want_hold[d] = 0;
      exp_first[d] = 0;
    end
    #1;
    for (int d = 0; d < 2; d++) begin
      check(ov[d] == 1'b0, "R1 out_valid after reset", int'(ov[d]), 0);
      check(ir[d] == 1'b1, "R1 in_ready after reset", int'(ir[d]), 1);
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    // impulse and first output after reset
    cycle(1, 32767, 1);
    for (int i = 0; i < 8; i++) cycle(1, 0, 1);
    // full-scale runs: clipping on u0, wrapping on u1
    for (int i = 0; i < 24; i++) cycle(1, 32767, 1);
    for (int i = 0; i < 24; i++) cycle(1, -32768, 1);
    // stall with a pending sample, then release (merged drain and accept)
    for (int i = 0; i < 5; i++) cycle(1, 12345, 0);
    for (int i = 0; i < 6; i++) cycle(1, -2000 * i, 1);
    // idle gaps must not move history
    cycle(1, 20000, 1);
    for (int i = 0; i < 6; i++) cycle(0, 31000, 1);
    cycle(1, -7, 1);
    cycle(0, 0, 1);
    // constrained random
    for (int i = 0; i < 4000; i++) begin
      int r, data;
      r = int'($urandom % 8);
      if (r == 0)      data = 32767;
      else if (r == 1) data = -32768;
      else             data = int'(shortint'($urandom));
      cycle(($urandom % 4) != 0, data, ($urandom % 3) != 0);
    end
    // reset in the middle restarts history
    do_reset();
    cycle(1, -32768, 1);
    cycle(1, 1000, 1);
    cycle(0, 0, 1);
    cycle(0, 0, 1);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule